// File: doc/BRIEF.md
# Instruction Fetch Address Checker

This block screens every word-sized instruction fetch address before the request goes on to the instruction cache or to memory. It forces the address onto a word boundary. It then compares the corrected address against a set of fixed address windows and reports at most one access flag, either an access error or an access exception. In one variant it also reports a misalignment flag. The priority among misalignment, error windows and exception windows depends on which of three checking variants is selected. A fourth select code turns checking off.

One small protected window near the bottom of the checked area can be opened by a region-enable control bit. While that bit is set, fetches into the window are allowed. While it is clear, they raise an access exception. The result is registered, so the corrected address and the flags appear on the cycle after the fetch strobe, together with a result-valid strobe. The surrounding fetch unit decides how to trap on the flags.

Top module: `fac_top`

## Requirements
- R1: While reset is asserted (asynchronously), and after it is released, `res_valid`, `res_addr` and all three flags read zero until the first fetch result arrives.
- R2: A fetch presented with `fetch_valid` high in one cycle yields `res_valid` high and its result on the following cycle. A cycle without `fetch_valid` drives `res_valid` low, and `res_addr` and the flags keep their previous values.
- R3: Select code 0 picks variant A, 1 picks variant B and 2 picks variant C. Code 3 passes the address through unchanged with all flags clear.
- R4: Variant A: an address with either of its low two bits set raises `flag_acc_err` and is returned with those bits cleared. `flag_misalign` stays low.
- R5: Variant A: a word-aligned address from 0xFE800000 to 0xFEFFFFFF raises `flag_acc_err`. No variant A address raises `flag_acc_exc`.
- R6: Variant B: an address with either of its low two bits set raises `flag_misalign` and is returned with those bits cleared. The window checks of R7 to R9 then apply to the corrected address.
- R7: Variant B: a corrected address from 0xFE800000 to 0xFEFEFFFF, or from 0xFEFF0600 to 0xFEFF7FFF, raises `flag_acc_err`. Addresses from 0xFEFF0000 to 0xFEFF05FF and from 0xFEFF8000 to 0xFEFFFFFF raise nothing.
- R8: Variant B: a corrected address from 0xFE004000 to 0xFE7FFFFF raises `flag_acc_exc`.
- R9: Variant B: a corrected address from 0xFE000000 to 0xFE003FFF raises `flag_acc_exc` when `region_en` is 0 and nothing when it is 1.
- R10: Variant C clears the low two address bits without raising any flag for misalignment. `flag_misalign` is never set outside variant B.
- R11: Variant C: a corrected address from 0xFE800000 to 0xFEFFFFFF raises `flag_acc_err`. One from 0xFE008000 to 0xFE7FFFFF raises `flag_acc_exc`.
- R12: Variant C: a corrected address from 0xFE000000 to 0xFE007FFF raises `flag_acc_exc` when `region_en` is 0 and nothing when it is 1.
- R13: `flag_acc_err` and `flag_acc_exc` are never high together. Error windows take priority over exception windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_addr | input | 32 | Fetch address to check |
| variant_sel | input | 2 | 0 = A, 1 = B, 2 = C, 3 = no checking |
| region_en | input | 1 | 1 opens the small protected window |
| res_valid | output | 1 | Result of the previous cycle's fetch is present |
| res_addr | output | 32 | Corrected fetch address |
| flag_misalign | output | 1 | Misaligned fetch (variant B) |
| flag_acc_err | output | 1 | Instruction access error |
| flag_acc_exc | output | 1 | Instruction access exception |

## Verification
The bench builds the block with its defaults, a 32-bit address and two alignment bits. With these values every window bound is at its full-width value, so the bench can place probes on the first and last word of each window and on the words just outside it. These probes include the gaps on either side of the variant B error window near the top of the checked area, and addresses that one variant flags and another does not. Misaligned probes land inside windows, which shows that the window tests run on the corrected address.

// File: rtl/fac_pkg.sv
package fac_pkg;

  typedef enum logic [1:0] {
    VAR_A    = 2'd0,
    VAR_B    = 2'd1,
    VAR_C    = 2'd2,
    VAR_PASS = 2'd3
  } fac_variant_e;

  typedef struct packed {
    logic misalign;
    logic acc_err;
    logic acc_exc;
  } fac_flags_t;

  // window indices
  localparam int WIN_ERR_WIDE = 0; // A and C error window
  localparam int WIN_B_ERR_LO = 1;
  localparam int WIN_B_ERR_HI = 2;
  localparam int WIN_B_EXC    = 3;
  localparam int WIN_B_PROT   = 4;
  localparam int WIN_C_EXC    = 5;
  localparam int WIN_C_PROT   = 6;
  localparam int NUM_WIN      = 7;

  function automatic logic [31:0] win_lo(input int idx);
    case (idx)
      WIN_ERR_WIDE: win_lo = 32'hFE80_0000;
      WIN_B_ERR_LO: win_lo = 32'hFE80_0000;
      WIN_B_ERR_HI: win_lo = 32'hFEFF_0600;
      WIN_B_EXC:    win_lo = 32'hFE00_4000;
      WIN_B_PROT:   win_lo = 32'hFE00_0000;
      WIN_C_EXC:    win_lo = 32'hFE00_8000;
      default:      win_lo = 32'hFE00_0000;
    endcase
  endfunction

  function automatic logic [31:0] win_hi(input int idx);
    case (idx)
      WIN_ERR_WIDE: win_hi = 32'hFEFF_FFFF;
      WIN_B_ERR_LO: win_hi = 32'hFEFE_FFFF;
      WIN_B_ERR_HI: win_hi = 32'hFEFF_7FFF;
      WIN_B_EXC:    win_hi = 32'hFE7F_FFFF;
      WIN_B_PROT:   win_hi = 32'hFE00_3FFF;
      WIN_C_EXC:    win_hi = 32'hFE7F_FFFF;
      default:      win_hi = 32'hFE00_7FFF;
    endcase
  endfunction

endpackage

// File: rtl/fac_window.sv
module fac_window #(
  parameter int              W  = 32,
  parameter logic [W-1:0]    LO = '0,
  parameter logic [W-1:0]    HI = '1
) (
  input  logic [W-1:0] addr,
  output logic         hit
);
  always_comb begin
    hit = (addr >= LO) && (addr <= HI);
  end
endmodule

// File: rtl/fac_rst_sync.sv
module fac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fac_classify.sv
module fac_classify
  import fac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        variant,
  input  logic              region_en,
  output logic [ADDR_W-1:0] corr_addr,
  output fac_flags_t        flags
);
  localparam logic [ADDR_W-1:0] LOW_MASK =
    {{(ADDR_W-ALIGN_BITS){1'b0}}, {ALIGN_BITS{1'b1}}};

  logic [ADDR_W-1:0] aligned_addr;
  logic              unaligned;
  logic [NUM_WIN-1:0] hit;

  always_comb begin
    unaligned    = |(addr & LOW_MASK);
    aligned_addr = addr & ~LOW_MASK;
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    fac_window #(
      .W (ADDR_W),
      .LO(ADDR_W'(win_lo(g))),
      .HI(ADDR_W'(win_hi(g)))
    ) u_win (
      .addr(aligned_addr),
      .hit (hit[g])
    );
  end

  always_comb begin
    corr_addr = aligned_addr;
    flags     = '0;
    case (fac_variant_e'(variant))
      VAR_A: begin
        // misalignment is itself reported as an access error
        flags.acc_err = unaligned | hit[WIN_ERR_WIDE];
      end
      VAR_B: begin
        flags.misalign = unaligned;
        if (hit[WIN_B_ERR_LO] | hit[WIN_B_ERR_HI])
          flags.acc_err = 1'b1;
        else if (hit[WIN_B_EXC])
          flags.acc_exc = 1'b1;
        else if (!region_en && hit[WIN_B_PROT])
          flags.acc_exc = 1'b1;
      end
      VAR_C: begin
        if (hit[WIN_ERR_WIDE])
          flags.acc_err = 1'b1;
        else if (hit[WIN_C_EXC])
          flags.acc_exc = 1'b1;
        else if (!region_en && hit[WIN_C_PROT])
          flags.acc_exc = 1'b1;
      end
      default: begin
        corr_addr = addr;
      end
    endcase
  end
endmodule

// File: rtl/fac_top.sv
module fac_top
  import fac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [1:0]        variant_sel,
  input  logic              region_en,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_addr,
  output logic              flag_misalign,
  output logic              flag_acc_err,
  output logic              flag_acc_exc
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] cls_addr;
  fac_flags_t        cls_flags;

  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  fac_flags_t        flags_q, flags_d;
  logic              load_en;

  fac_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  fac_classify #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_cls (
    .addr     (fetch_addr),
    .variant  (variant_sel),
    .region_en(region_en),
    .corr_addr(cls_addr),
    .flags    (cls_flags)
  );

  // next state
  always_comb begin
    load_en = fetch_valid;
    valid_d = fetch_valid;
    addr_d  = addr_q;
    flags_d = flags_q;
    if (load_en) begin
      addr_d  = cls_addr;
      flags_d = cls_flags;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      flags_q <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      flags_q <= flags_d;
    end
  end

  assign res_valid     = valid_q;
  assign res_addr      = addr_q;
  assign flag_misalign = flags_q.misalign;
  assign flag_acc_err  = flags_q.acc_err;
  assign flag_acc_exc  = flags_q.acc_exc;
endmodule

// File: rtl/fac_checker.sv
module fac_checker #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [1:0]        variant_sel,
  input logic              res_valid,
  input logic [ADDR_W-1:0] res_addr,
  input logic              flag_misalign,
  input logic              flag_acc_err,
  input logic              flag_acc_exc
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_acc_err && flag_acc_exc)); // R13

  AST_VALID_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> res_valid); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> (!res_valid && $stable(res_addr))); // R2

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(variant_sel) != 2'd3) |-> (res_addr[ALIGN_BITS-1:0] == '0)); // R10

  AST_MISALIGN_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && flag_misalign) |-> ($past(variant_sel) == 2'd1)); // R10

  AST_PASS_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(variant_sel) == 2'd3) |->
      !(flag_misalign || flag_acc_err || flag_acc_exc)); // R3
endmodule

bind fac_top fac_checker #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .fetch_valid  (fetch_valid),
  .variant_sel  (variant_sel),
  .res_valid    (res_valid),
  .res_addr     (res_addr),
  .flag_misalign(flag_misalign),
  .flag_acc_err (flag_acc_err),
  .flag_acc_exc (flag_acc_exc)
);

// File: tb/tb_fac_top.sv
module tb_fac_top;
  localparam int CLK_P = 10;
  localparam int NV    = 26;

  logic        clk;
  logic        rst_n;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic [1:0]  variant_sel;
  logic        region_en;
  logic        res_valid;
  logic [31:0] res_addr;
  logic        flag_misalign, flag_acc_err, flag_acc_exc;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  fac_top dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .variant_sel(variant_sel), .region_en(region_en), .res_valid(res_valid),
    .res_addr(res_addr), .flag_misalign(flag_misalign), .flag_acc_err(flag_acc_err),
    .flag_acc_exc(flag_acc_exc)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // {req[3:0], variant[1:0], region_en, addr[31:0], exp_addr[31:0], mis, err, exc}
  localparam logic [73:0] VEC [NV] = '{
    {4'd4,  2'd0, 1'b0, 32'h0000_1002, 32'h0000_1000, 3'b010}, // R4
    {4'd5,  2'd0, 1'b0, 32'hFE80_0000, 32'hFE80_0000, 3'b010}, // R5
    {4'd5,  2'd0, 1'b0, 32'hFEFF_FFFC, 32'hFEFF_FFFC, 3'b010}, // R5
    {4'd5,  2'd0, 1'b0, 32'hFE7F_FFFC, 32'hFE7F_FFFC, 3'b000}, // R5
    {4'd5,  2'd0, 1'b0, 32'hFE00_0000, 32'hFE00_0000, 3'b000}, // R5
    {4'd4,  2'd0, 1'b1, 32'hFE80_0001, 32'hFE80_0000, 3'b010}, // R4
    {4'd6,  2'd1, 1'b0, 32'h0000_2003, 32'h0000_2000, 3'b100}, // R6
    {4'd6,  2'd1, 1'b0, 32'hFEFF_0603, 32'hFEFF_0600, 3'b110}, // R6
    {4'd7,  2'd1, 1'b0, 32'hFEFF_0600, 32'hFEFF_0600, 3'b010}, // R7
    {4'd7,  2'd1, 1'b0, 32'hFEFF_05FC, 32'hFEFF_05FC, 3'b000}, // R7
    {4'd7,  2'd1, 1'b0, 32'hFEFF_8000, 32'hFEFF_8000, 3'b000}, // R7
    {4'd7,  2'd1, 1'b0, 32'hFEFE_FFFC, 32'hFEFE_FFFC, 3'b010}, // R7
    {4'd8,  2'd1, 1'b1, 32'hFE00_4000, 32'hFE00_4000, 3'b001}, // R8
    {4'd8,  2'd1, 1'b1, 32'hFE7F_FFFC, 32'hFE7F_FFFC, 3'b001}, // R8
    {4'd9,  2'd1, 1'b0, 32'hFE00_3FFC, 32'hFE00_3FFC, 3'b001}, // R9
    {4'd9,  2'd1, 1'b1, 32'hFE00_3FFC, 32'hFE00_3FFC, 3'b000}, // R9
    {4'd9,  2'd1, 1'b0, 32'hFE00_0002, 32'hFE00_0000, 3'b101}, // R9
    {4'd8,  2'd1, 1'b1, 32'hFE7F_FFFE, 32'hFE7F_FFFC, 3'b101}, // R8
    {4'd10, 2'd2, 1'b0, 32'h0000_3003, 32'h0000_3000, 3'b000}, // R10
    {4'd11, 2'd2, 1'b0, 32'hFEFF_FFFF, 32'hFEFF_FFFC, 3'b010}, // R11
    {4'd11, 2'd2, 1'b1, 32'hFE00_8000, 32'hFE00_8000, 3'b001}, // R11
    {4'd12, 2'd2, 1'b0, 32'hFE00_7FFC, 32'hFE00_7FFC, 3'b001}, // R12
    {4'd12, 2'd2, 1'b1, 32'hFE00_7FFC, 32'hFE00_7FFC, 3'b000}, // R12
    {4'd11, 2'd2, 1'b1, 32'hFE00_4000, 32'hFE00_4000, 3'b000}, // R11
    {4'd11, 2'd2, 1'b0, 32'hFDFF_FFFC, 32'hFDFF_FFFC, 3'b000}, // R11
    {4'd3,  2'd3, 1'b0, 32'hFE80_0003, 32'hFE80_0003, 3'b000}  // R3
  };

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] outs();
    return {res_valid, res_addr, flag_misalign, flag_acc_err, flag_acc_exc};
  endfunction

  initial begin
    #(CLK_P*200000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [35:0] held;
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_addr = '0; variant_sel = '0; region_en = 1'b0;
    #(CLK_P*3 + 1);
    check("R1 in reset", outs(), 36'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", outs(), 36'h0);

    // table walk, one fetch per cycle back to back
    for (int i = 0; i <= NV; i++) begin
      if (i > 0) begin
        logic [73:0] v;
        v = VEC[i-1];
        check($sformatf("R%0d vec%0d", v[73:70], i-1), outs(), {1'b1, v[34:0]});
        check("R13 exclusive", {35'h0, flag_acc_err & flag_acc_exc}, 36'h0);
      end
      if (i < NV) begin
        logic [73:0] v;
        v = VEC[i];
        fetch_valid = 1'b1;
        variant_sel = v[69:68];
        region_en   = v[67];
        fetch_addr  = v[66:35];
      end else begin
        fetch_valid = 1'b0;
        fetch_addr  = 32'h1234_5677;
        variant_sel = 2'd1;
      end
      @(negedge clk);
    end

    // R2: idle cycles hold the last result with valid low (last vector was code 3)
    held = {1'b0, 32'hFE80_0003, 3'b000};
    check("R2 idle hold", outs(), held);
    @(negedge clk);
    check("R2 idle hold 2", outs(), held);

    // R2: single fetch then idle
    fetch_valid = 1'b1; variant_sel = 2'd1; region_en = 1'b0; fetch_addr = 32'hFE00_0001;
    @(negedge clk);
    fetch_valid = 1'b0; fetch_addr = 32'hFE80_0000; variant_sel = 2'd0;
    check("R2 single fetch", outs(), {1'b1, 32'hFE00_0000, 3'b101});
    @(negedge clk);
    check("R2 after single", outs(), {1'b0, 32'hFE00_0000, 3'b101});

    // R1: asynchronous reset mid-run clears everything
    #(CLK_P/4);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", outs(), 36'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after second release", outs(), 36'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule